// File: doc/BRIEF.md
# Rotate and Wrapping Mask Unit

This block is the rotate-and-mask datapath of a 64-bit fixed-point pipe that can also run in a 32-bit mode. It takes one source operand, rotates it left, and ANDs the rotated value with a mask. The mask is a contiguous run of ones that wraps around the word ends when its begin position is greater than its end position. Bit positions count from the most significant bit, which is position 0.

In the doubleword form the whole 64-bit operand is rotated by a 6-bit amount, and the mask limits are 6-bit positions. In the word form the low 32 bits of the operand are copied into both halves before rotating, the rotate amount is 5 bits, and the 5-bit mask limits are offset by 32 so that they fall in the low word.

Each accepted operation produces a registered result one clock after its strobe. When recording is requested, it also updates a 4-bit condition field that classifies the result as a signed value. In 32-bit mode that classification looks only at the low word.

Top module: `rotm_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and is low otherwise; `result` and `cond` for an operation appear in that same cycle.
- R2: With `word_form`=0, `result` equals the 64-bit `src` rotated left by `sh` (0..63), ANDed with the mask.
- R3: Mask positions are numbered with position 0 as the most significant bit (`result[63]`). With begin `mb` not greater than end `me`, the mask has ones at positions `mb` through `me` inclusive, and zeros elsewhere.
- R4: With `mb` greater than `me`, the mask has ones at positions `mb` through 63 and at positions 0 through `me`. With `mb` equal to `me`, exactly one position is set.
- R5: With `word_form`=1, the operand is `src[31:0]` concatenated with itself. It is rotated left by `sh[4:0]`, and the mask uses begin `mb[4:0]`+32 and end `me[4:0]`+32. `sh[5]`, `mb[5]`, `me[5]` and `src[63:32]` have no effect in this form.
- R6: A rotate amount of zero leaves the operand unrotated. With a full mask (`mb`=0, `me`=63, doubleword form) the result equals `src`.
- R7: When `rec_en` is 1, `cond` is written: `cond[3]`=1 if the result is negative, `cond[2]`=1 if it is positive, `cond[1]`=1 if it is zero, and exactly one of these three is set. With `mode32`=0 the whole 64-bit result is taken as signed.
- R8: With `mode32`=1, the condition bits are taken from `result[31:0]` as a signed 32-bit value, whatever the upper word holds.
- R9: When `rec_en` is 1, `cond[0]` takes the value of `so_in` sampled with the strobe.
- R10: When `rec_en` is 0, `cond` keeps its previous value and `cond_wr` is low. `cond_wr` is high alongside `out_valid` only for recorded operations.
- R11: After reset, `out_valid`, `result`, `cond` and `cond_wr` are all zero.
- R12: In cycles after a cycle with no strobe, `result` and `cond` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| src | input | 64 | Source operand |
| sh | input | 6 | Rotate amount (bit 5 used in doubleword form only) |
| mb | input | 6 | Mask begin position |
| me | input | 6 | Mask end position |
| word_form | input | 1 | 1 selects the word form, 0 the doubleword form |
| rec_en | input | 1 | 1 updates the condition field |
| mode32 | input | 1 | 1 evaluates the condition on the low word |
| so_in | input | 1 | Summary-overflow value copied into cond[0] |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 64 | Rotated and masked result |
| cond | output | 4 | Condition field {neg, pos, zero, so} |
| cond_wr | output | 1 | High with out_valid when cond was written |

## Verification
A faulty rotate stage, or a mask limit that is off by one, shows up in `result` on the cycle after the strobe that exercises it. The error only appears for amounts whose bit selects the broken stage, and for masks whose edge lands on the broken position. Wrapped masks, coinciding limits and both forms are therefore each driven explicitly. A stale or wrongly updated condition register is visible in `cond` on the first `out_valid` after the faulty update, and it stays visible through every later non-recording operation until the next recorded one.

// File: rtl/rotm_pkg.sv
package rotm_pkg;
    localparam int XLEN = 64;
    localparam int HALF = XLEN / 2;
    localparam int SHW  = $clog2(XLEN);
    localparam int CW   = 4;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] result;
        logic [CW-1:0]   cond;
        logic            cond_wr;
    } rotm_state_t;
endpackage

// File: rtl/rotm_rotator.sv
module rotm_rotator
    import rotm_pkg::*;
(
    input  logic [XLEN-1:0] opnd,
    input  logic [SHW-1:0]  amt,
    output logic [XLEN-1:0] rotated
);
    logic [XLEN-1:0] stage [SHW+1];

    assign stage[0] = opnd;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stage[s+1] = amt[s] ? {stage[s][XLEN-1-D:0], stage[s][XLEN-1:XLEN-D]}
                                   : stage[s];
    end

    assign rotated = stage[SHW];
endmodule

// File: rtl/rotm_mask_gen.sv
module rotm_mask_gen
    import rotm_pkg::*;
(
    input  logic [SHW-1:0]  first,
    input  logic [SHW-1:0]  last,
    output logic [XLEN-1:0] mask
);
    logic wraps;
    assign wraps = first > last;

    for (genvar p = 0; p < XLEN; p++) begin : g_bit
        localparam logic [SHW-1:0] POS = SHW'(p);
        logic above, below;
        assign above = POS >= first;
        assign below = POS <= last;
        assign mask[XLEN-1-p] = wraps ? (above | below) : (above & below);
    end
endmodule

// File: rtl/rotm_cond_eval.sv
module rotm_cond_eval
    import rotm_pkg::*;
(
    input  logic [XLEN-1:0] value,
    input  logic            narrow,
    input  logic            so,
    output logic [CW-1:0]   flags
);
    logic sign_bit;
    logic is_zero;

    always_comb begin
        sign_bit = narrow ? value[HALF-1] : value[XLEN-1];
        is_zero  = narrow ? (value[HALF-1:0] == '0) : (value == '0);
        flags    = {sign_bit, ~sign_bit & ~is_zero, is_zero, so};
    end
endmodule

// File: rtl/rotm_unit.sv
module rotm_unit
    import rotm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] src,
    input  logic [SHW-1:0]  sh,
    input  logic [SHW-1:0]  mb,
    input  logic [SHW-1:0]  me,
    input  logic            word_form,
    input  logic            rec_en,
    input  logic            mode32,
    input  logic            so_in,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic [CW-1:0]   cond,
    output logic            cond_wr
);
    rotm_state_t state_d, state_q;

    logic [XLEN-1:0] opnd_sel;
    logic [SHW-1:0]  amt_sel;
    logic [SHW-1:0]  first_sel;
    logic [SHW-1:0]  last_sel;
    logic [XLEN-1:0] rotated;
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] masked;
    logic [CW-1:0]   flags;

    always_comb begin
        if (word_form) begin
            opnd_sel  = {src[HALF-1:0], src[HALF-1:0]};
            amt_sel   = {1'b0, sh[SHW-2:0]};
            first_sel = {1'b1, mb[SHW-2:0]};
            last_sel  = {1'b1, me[SHW-2:0]};
        end else begin
            opnd_sel  = src;
            amt_sel   = sh;
            first_sel = mb;
            last_sel  = me;
        end
    end

    rotm_rotator u_rot (
        .opnd    (opnd_sel),
        .amt     (amt_sel),
        .rotated (rotated)
    );

    rotm_mask_gen u_mask (
        .first (first_sel),
        .last  (last_sel),
        .mask  (mask)
    );

    assign masked = rotated & mask;

    rotm_cond_eval u_cond (
        .value  (masked),
        .narrow (mode32),
        .so     (so_in),
        .flags  (flags)
    );

    always_comb begin
        state_d         = state_q;
        state_d.valid   = in_valid;
        state_d.cond_wr = in_valid & rec_en;
        if (in_valid) begin
            state_d.result = masked;
            if (rec_en) begin
                state_d.cond = flags;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign result    = state_q.result;
    assign cond      = state_q.cond;
    assign cond_wr   = state_q.cond_wr;
endmodule

// File: rtl/rotm_unit_chk.sv
module rotm_unit_chk
    import rotm_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XLEN-1:0] src,
    input logic [SHW-1:0]  sh,
    input logic [SHW-1:0]  mb,
    input logic [SHW-1:0]  me,
    input logic            word_form,
    input logic            rec_en,
    input logic            so_in,
    input logic            out_valid,
    input logic [XLEN-1:0] result,
    input logic [CW-1:0]   cond,
    input logic            cond_wr
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r6_full_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !word_form && sh == '0 && mb == '0 && me == SHW'(XLEN-1))
        |=> result == $past(src));

    a_r7_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rec_en) |=> $countones(cond[3:1]) == 1);

    a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cond_wr && result == '0) |-> cond[1]);

    a_r9_so_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rec_en) |=> cond[0] == $past(so_in));

    a_r10_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rec_en) |=> !cond_wr);

    a_r10_cond_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && rec_en) |=> $stable(cond));

    a_r12_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
endmodule

bind rotm_unit rotm_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src       (src),
    .sh        (sh),
    .mb        (mb),
    .me        (me),
    .word_form (word_form),
    .rec_en    (rec_en),
    .so_in     (so_in),
    .out_valid (out_valid),
    .result    (result),
    .cond      (cond),
    .cond_wr   (cond_wr)
);

// File: tb/rotm_unit_bench.sv
`timescale 1ns/1ps
module rotm_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] src = '0;
    logic [5:0]  sh = '0;
    logic [5:0]  mb = '0;
    logic [5:0]  me = '0;
    logic        word_form = 1'b0;
    logic        rec_en = 1'b0;
    logic        mode32 = 1'b0;
    logic        so_in = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic [3:0]  cond;
    logic        cond_wr;

    always #4 clk = ~clk;

    rotm_unit u_rotm_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .sh(sh),
        .mb(mb), .me(me), .word_form(word_form), .rec_en(rec_en),
        .mode32(mode32), .so_in(so_in), .out_valid(out_valid),
        .result(result), .cond(cond), .cond_wr(cond_wr)
    );

    typedef struct {
        logic [63:0] res;
        logic [3:0]  cnd;
        logic        wr;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          fails = 0;
    bit          finished = 0;
    logic [3:0]  model_cond = '0;
    logic [63:0] model_res = '0;
    logic [63:0] last_res = '0;
    logic [3:0]  last_cond = '0;
    bit          have_last = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_result(logic [63:0] s, logic [5:0] amt6,
            logic [5:0] b6, logic [5:0] e6, logic wf);
        logic [63:0] op;
        logic [63:0] r;
        int amt, b, e;
        op  = wf ? {s[31:0], s[31:0]} : s;
        amt = wf ? int'(amt6[4:0]) : int'(amt6);
        b   = wf ? 32 + int'(b6[4:0]) : int'(b6);
        e   = wf ? 32 + int'(e6[4:0]) : int'(e6);
        r   = '0;
        for (int p = 0; p < 64; p++) begin
            bit inm;
            inm = (b <= e) ? (p >= b && p <= e) : (p >= b || p <= e);
            r[63-p] = inm & op[63 - ((p + amt) % 64)];
        end
        return r;
    endfunction

    function automatic logic [3:0] ref_cond(logic [63:0] r, logic m32, logic so);
        longint v;
        v = m32 ? longint'($signed(r[31:0])) : $signed(r);
        return {v < 0, v > 0, v == 0, so};
    endfunction

    task automatic send(input logic [63:0] s, input logic [5:0] a, input logic [5:0] b,
                        input logic [5:0] e, input logic wf, input logic rec,
                        input logic m32, input logic so, input string tag);
        exp_t it;
        @(negedge clk);
        src = s; sh = a; mb = b; me = e; word_form = wf;
        rec_en = rec; mode32 = m32; so_in = so; in_valid = 1'b1;
        model_res = ref_result(s, a, b, e, wf);
        if (rec) model_cond = ref_cond(model_res, m32, so);
        it.res = model_res; it.cnd = model_cond; it.wr = rec; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            src = {2{32'hdead_beef}}; sh = 6'd13; rec_en = 1'b1;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R1 unexpected out_valid", 64'(out_valid), 64'd0);
                end else begin
                    exp_t it;
                    it = q.pop_front();
                    chk(result === it.res, {it.tag, " result"}, result, it.res);
                    chk(cond === it.cnd, {it.tag, " cond"}, 64'(cond), 64'(it.cnd));
                    chk(cond_wr === it.wr, "R10 cond_wr", 64'(cond_wr), 64'(it.wr));
                    last_res = it.res; last_cond = it.cnd; have_last = 1;
                end
            end else if (have_last) begin
                chk(result === last_res, "R12 result hold", result, last_res);
                chk(cond === last_cond, "R12 cond hold", 64'(cond), 64'(last_cond));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] pat;
        pat = 64'h0123_4567_89ab_cdef;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(out_valid === 1'b0, "R11 out_valid", 64'(out_valid), 64'd0);
        chk(result === '0, "R11 result", result, 64'd0);
        chk(cond === '0, "R11 cond", 64'(cond), 64'd0);
        chk(cond_wr === 1'b0, "R11 cond_wr", 64'(cond_wr), 64'd0);
        rst_n = 1'b1;
        idle(2);

        send(pat, 6'd8,  6'd0,  6'd63, 0, 1, 0, 0, "R2 rot8 full");
        send(pat, 6'd37, 6'd0,  6'd63, 0, 1, 0, 0, "R2 rot37 full");
        idle(1);
        send(pat, 6'd0,  6'd8,  6'd15, 0, 1, 0, 0, "R3 field 8..15");
        send(64'hffff_ffff_ffff_ffff, 6'd0, 6'd0, 6'd0, 0, 1, 0, 0, "R3 msb only");
        send(64'hffff_ffff_ffff_ffff, 6'd0, 6'd60, 6'd3, 0, 1, 0, 0, "R4 wrap 60..3");
        send(pat, 6'd4,  6'd33, 6'd33, 0, 1, 0, 0, "R4 single bit");
        send(pat, 6'd17, 6'd63, 6'd0, 0, 1, 0, 0, "R4 wrap ends");
        send(64'hfedc_ba98_8000_0001, 6'b100101, 6'b100000, 6'b111111, 1, 1, 0, 0, "R5 word rot5");
        send(64'h1111_2222_89ab_cdef, 6'd3, 6'd20, 6'd3, 1, 1, 0, 0, "R5 word wrap");
        send(64'h0000_0000_89ab_cdef, 6'd3, 6'd20, 6'd3, 1, 1, 0, 0, "R5 upper ignored");
        send(pat, 6'd0,  6'd0,  6'd63, 0, 1, 0, 0, "R6 passthrough");
        idle(3);
        send(64'h8000_0000_0000_0000, 6'd0, 6'd0, 6'd63, 0, 1, 0, 0, "R7 negative");
        send(64'h0000_0000_0000_0005, 6'd0, 6'd0, 6'd63, 0, 1, 0, 0, "R7 positive");
        send(pat, 6'd0, 6'd8, 6'd7, 0, 1, 0, 0, "R7 wrap full");
        send(pat, 6'd0, 6'd0, 6'd7, 0, 1, 0, 1, "R9 so set");
        send(64'h0, 6'd9, 6'd0, 6'd63, 0, 1, 0, 0, "R7 zero");
        send(64'h8000_0000_0000_0001, 6'd0, 6'd0, 6'd63, 0, 1, 1, 0, "R8 low positive");
        send(64'hffff_ffff_0000_0000, 6'd0, 6'd0, 6'd63, 0, 1, 1, 1, "R8 low zero");
        send(64'h0000_0000_8000_0000, 6'd0, 6'd0, 6'd63, 0, 1, 1, 0, "R8 low negative");
        send(64'h8000_0000_0000_0000, 6'd0, 6'd0, 6'd63, 0, 0, 0, 1, "R10 no record");
        send(64'h0, 6'd0, 6'd0, 6'd63, 0, 0, 1, 0, "R10 no record zero");
        idle(2);
        for (int i = 0; i < 300; i++) begin
            send({$urandom, $urandom}, 6'($urandom), 6'($urandom), 6'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R2 R5 sweep");
            if (i % 7 == 0) idle(1);
        end
        idle(4);
        chk(q.size() == 0, "R1 queue drained", 64'(q.size()), 64'd0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule